// File: doc/BRIEF.md
# Point-to-Point Adaptive Voltage Serial Target

This block is the target end of a two-party serial link that a host uses to set a supply voltage. Three wires carry it: a serial clock, a host-to-target data line and a target-to-host data line. There is no select wire, so the block finds each frame from the data itself. While nothing is being sent, the host data line rests high and the clock rests low. The first bit of every frame is a zero, and the falling host data line that this produces marks the start of the frame.

All three wires are brought into the system clock domain through a two-stage synchroniser. Clock edges are found by comparing successive samples; the serial clock never clocks a flop. Incoming bits are captured on falling serial clock edges, most significant bit first. Each frame is 32 bits long. When a frame ends, the block checks its 3-bit CRC and decodes it. A valid write updates a registered voltage target and pulses a strobe for one cycle. A read leaves the target unchanged. Every frame, whatever its content, sets up the reply that goes back during the next frame. That reply carries a status code, an alert bit, five flag bits taken from inputs, the current target and a CRC. The block changes its output bits after rising serial clock edges. It drives the first reply bit as soon as it sees the start of a frame.

Host frame layout, most significant bit first: [31:30] start pattern (must be 01), [29:28] command, [27] group, [26:23] data type, [22:19] rail select, [18:3] payload, [2:0] CRC. Reply layout: [31:30] status, [29] alert, [28:24] flags, [23:8] readback, [7:3] all ones, [2:0] CRC.

Top module: `avs_target`

## Requirements
- R1: After reset the target data line is high, the voltage target holds the parameter VT_RESET and the strobe is low. The reply sent during the first frame has status 00, alert 0, flags 0 and readback VT_RESET.
- R2: A frame starts only when the host data line falls while the block is idle. The block then captures exactly 32 bits on falling serial clock edges, most significant bit first. Serial clock toggles while the host data line stays high start nothing.
- R3: Command 00 (write) with data type 0 in a frame that is addressed and well formed loads the payload into the voltage target. The strobe goes high for exactly one system cycle, once per such frame, even when the value is unchanged.
- R4: The CRC uses polynomial x^3+x+1 with initial value 111. It covers bits [31:3], most significant bit first. If it does not match, the target is unchanged, no strobe is raised, and the next reply reports status 11.
- R5: A frame is addressed when the group bit is 1, or when the rail select equals RAIL_ID. A frame that is not addressed, or whose data type is not 0, changes nothing and produces status 01.
- R6: Command 11 (read) on a valid frame raises no strobe and changes nothing. The next reply reports status 00 with the current target as readback.
- R7: The reply uses the layout above, and its CRC uses the R4 rule over reply bits [31:3]. Its first bit is driven once the frame start is seen, and each later bit follows a rising serial clock edge. Between frames the target data line is high.
- R8: Commands 01 and 10 are reserved. A frame carrying one changes nothing and produces status 01.
- R9: A frame whose start pattern is not 01 is treated as malformed. It changes nothing and produces status 11, which takes priority over status 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the host, asynchronous |
| m2s_i | input | 1 | Host-to-target serial data, asynchronous |
| s2m_o | output | 1 | Target-to-host serial data, registered |
| flags_i | input | 5 | Status flags copied into the next reply |
| alert_i | input | 1 | Alert bit copied into the next reply |
| vtarget_o | output | 16 | Decoded voltage target, registered |
| vtarget_vld_o | output | 1 | One-cycle strobe when the voltage target is loaded |

## Verification
If the bit counter or frame state goes wrong, the error shows within one frame. The next reply arrives shifted or garbled and fails its CRC comparison, and the target data line is found low at the idle check after the frame. A wrong decision in the decoder shows up a few system cycles after the last falling serial clock edge, as a wrong target value or an extra or missing strobe. It also shows as a wrong status code in the reply during the following frame. Random frames mix good and corrupted CRCs, every command, the group bit and both matching and other rails. Directed frames cover malformed starts, idle serial clocks and extreme payloads.

// File: rtl/avs_tgt_pkg.sv
package avs_tgt_pkg;

  localparam int FRAME_W = 32;
  localparam int CRC_W   = 3;
  localparam int DATA_W  = 16;
  localparam int FLAG_W  = 5;
  localparam int BODY_W  = FRAME_W - CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int PAD_W   = BODY_W - 2 - 1 - FLAG_W - DATA_W;

  typedef enum logic [1:0] {
    ST_OK       = 2'b00,
    ST_REJECT   = 2'b01,
    ST_BADFRAME = 2'b11
  } st_e;

  localparam logic [1:0] CMD_WRITE = 2'b00;
  localparam logic [1:0] CMD_READ  = 2'b11;
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [3:0] TYPE_VOLT = 4'h0;

  // serial CRC, x^3 + x + 1, preset to all ones, MSB first
  function automatic logic [CRC_W-1:0] crc_calc(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '1;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = body[i] ^ c[2];
      c  = {c[1], c[0] ^ fb, fb};
    end
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] resp_build(input st_e st, input logic alert,
                                                     input logic [FLAG_W-1:0] flags,
                                                     input logic [DATA_W-1:0] rb);
    logic [BODY_W-1:0] body;
    body = {st, alert, flags, rb, {PAD_W{1'b1}}};
    return {body, crc_calc(body)};
  endfunction

endpackage

// File: rtl/avs_tgt_sync.sv
module avs_tgt_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/avs_tgt_rx.sv
module avs_tgt_rx
  import avs_tgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s_i,
  input  logic               mosi_s_i,
  output logic               rise_o,
  output logic               start_o,
  output logic               active_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o
);

  logic               sclk_d, mosi_d;
  logic               rise_q, start_q, active_q, done_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sr_q;
  logic               sclk_fall, mosi_fall;

  assign sclk_fall = sclk_d & ~sclk_s_i;
  assign mosi_fall = mosi_d & ~mosi_s_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      mosi_d   <= 1'b1;
      rise_q   <= 1'b0;
      start_q  <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
    end else begin
      sclk_d  <= sclk_s_i;
      mosi_d  <= mosi_s_i;
      rise_q  <= sclk_s_i & ~sclk_d;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      if (!active_q) begin
        // idle-high data line dropping marks a new frame
        if (mosi_fall) begin
          active_q <= 1'b1;
          start_q  <= 1'b1;
          cnt_q    <= '0;
        end
      end else if (sclk_fall) begin
        sr_q <= {sr_q[FRAME_W-2:0], mosi_s_i};
        if (cnt_q == CNT_W'(FRAME_W - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rise_o   = rise_q;
  assign start_o  = start_q;
  assign active_o = active_q;
  assign done_o   = done_q;
  assign frame_o  = sr_q;

  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
    start_q |-> ($past(!active_q) && active_q));

  p_cnt_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> (cnt_q == '0));

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/avs_tgt_tx.sv
module avs_tgt_tx
  import avs_tgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               rise_i,
  input  logic               active_i,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] resp_i,
  output logic               miso_o
);

  logic [FRAME_W-1:0] sr_q;
  logic               miso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '1;
      miso_q <= 1'b1;
    end else if (start_i) begin
      miso_q <= resp_i[FRAME_W-1];
      sr_q   <= {resp_i[FRAME_W-2:0], 1'b1};
    end else if (rise_i && active_i) begin
      miso_q <= sr_q[FRAME_W-1];
      sr_q   <= {sr_q[FRAME_W-2:0], 1'b1};
    end else if (done_i) begin
      miso_q <= 1'b1;
    end
  end

  assign miso_o = miso_q;

  p_idle_high_r7: assert property (@(posedge clk) disable iff (rst)
    (!active_i && !done_i) |-> miso_q);

  p_first_bit_r7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (miso_q == $past(resp_i[FRAME_W-1])));

endmodule

// File: rtl/avs_tgt_decode.sv
module avs_tgt_decode
  import avs_tgt_pkg::*;
#(
  parameter logic [3:0]        RAIL_ID  = 4'h3,
  parameter logic [DATA_W-1:0] VT_RESET = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic               alert_i,
  output logic [DATA_W-1:0]  vt_o,
  output logic               vld_o,
  output logic [FRAME_W-1:0] resp_o
);

  logic [1:0]        f_start, f_cmd;
  logic              f_grp;
  logic [3:0]        f_type, f_rail;
  logic [DATA_W-1:0] f_pay;
  logic [CRC_W-1:0]  f_crc;
  logic              crc_ok, start_ok, addr_ok, cmd_ok, apply_c;
  st_e               status_c;
  logic [DATA_W-1:0] vt_nxt, vt_q;
  logic              vld_q;
  logic [FRAME_W-1:0] resp_q;

  assign {f_start, f_cmd, f_grp, f_type, f_rail, f_pay, f_crc} = frame_i;

  always_comb begin
    crc_ok   = (f_crc == crc_calc(frame_i[FRAME_W-1:CRC_W]));
    start_ok = (f_start == START_PAT);
    addr_ok  = f_grp || (f_rail == RAIL_ID);
    cmd_ok   = (f_cmd == CMD_WRITE) || (f_cmd == CMD_READ);
    if (!crc_ok || !start_ok)                         status_c = ST_BADFRAME;
    else if (!cmd_ok || !addr_ok || f_type != TYPE_VOLT) status_c = ST_REJECT;
    else                                              status_c = ST_OK;
    apply_c = done_i && (status_c == ST_OK) && (f_cmd == CMD_WRITE);
    vt_nxt  = apply_c ? f_pay : vt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vt_q   <= VT_RESET;
      vld_q  <= 1'b0;
      resp_q <= resp_build(ST_OK, 1'b0, '0, VT_RESET);
    end else begin
      vld_q <= apply_c;
      vt_q  <= vt_nxt;
      if (done_i) resp_q <= resp_build(status_c, alert_i, flags_i, vt_nxt);
    end
  end

  assign vt_o   = vt_q;
  assign vld_o  = vld_q;
  assign resp_o = resp_q;

  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

  p_strobe_after_frame_r3: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> $past(done_i));

  p_target_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(vt_q) |-> vld_q);

  p_bad_crc_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (done_i && !crc_ok) |=> (!vld_q && resp_q[FRAME_W-1 -: 2] == ST_BADFRAME));

  p_resp_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> $stable(resp_q));

endmodule

// File: rtl/avs_target.sv
module avs_target
  import avs_tgt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [3:0]        RAIL_ID     = 4'h3,
  parameter logic [DATA_W-1:0] VT_RESET    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              m2s_i,
  output logic              s2m_o,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              alert_i,
  output logic [DATA_W-1:0] vtarget_o,
  output logic              vtarget_vld_o
);

  logic [1:0]         pins_s;
  logic               rise, start, active, done;
  logic [FRAME_W-1:0] frame, resp;

  // bit 1: data line (rests high), bit 0: serial clock (rests low)
  avs_tgt_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) sync_i (
    .clk(clk), .rst(rst), .d_i({m2s_i, ser_clk_i}), .q_o(pins_s)
  );

  avs_tgt_rx rx_i (
    .clk(clk), .rst(rst), .sclk_s_i(pins_s[0]), .mosi_s_i(pins_s[1]),
    .rise_o(rise), .start_o(start), .active_o(active), .done_o(done), .frame_o(frame)
  );

  avs_tgt_decode #(.RAIL_ID(RAIL_ID), .VT_RESET(VT_RESET)) dec_i (
    .clk(clk), .rst(rst), .done_i(done), .frame_i(frame), .flags_i(flags_i),
    .alert_i(alert_i), .vt_o(vtarget_o), .vld_o(vtarget_vld_o), .resp_o(resp)
  );

  avs_tgt_tx tx_i (
    .clk(clk), .rst(rst), .start_i(start), .rise_i(rise), .active_i(active),
    .done_i(done), .resp_i(resp), .miso_o(s2m_o)
  );

endmodule

// File: tb/avs_target_tb_top.sv
module avs_target_tb_top;

  localparam logic [3:0]  RAIL  = 4'h3;
  localparam logic [15:0] VTR   = 16'h0200;
  localparam int          HP    = 8;
  localparam int          GAP   = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b1;
  logic [4:0]  flags = '0;
  logic        alert = 1'b0;
  logic        miso, vld;
  logic [15:0] vt;

  int checks = 0;
  int fails = 0;
  int vld_cnt = 0;
  bit finished = 0;
  logic [15:0] exp_vt;
  logic [31:0] exp_resp;

  always #4 clk = ~clk;

  avs_target #(.SYNC_STAGES(2), .RAIL_ID(RAIL), .VT_RESET(VTR)) dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .m2s_i(mosi), .s2m_o(miso),
    .flags_i(flags), .alert_i(alert), .vtarget_o(vt), .vtarget_vld_o(vld)
  );

  always @(negedge clk) if (!rst && vld) vld_cnt++;

  // CRC as polynomial remainder: (msg*x^3 + 111*x^29) mod 1011
  function automatic logic [2:0] crc_ref(input logic [28:0] b);
    logic [31:0] r;
    r = {b, 3'b000} ^ {3'b111, 29'b0};
    for (int i = 31; i >= 3; i--)
      if (r[i]) r = r ^ (32'b1011 << (i - 3));
    return r[2:0];
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] st, input logic [1:0] cmd,
                                     input logic grp, input logic [3:0] typ,
                                     input logic [3:0] rail, input logic [15:0] pay);
    logic [28:0] b;
    b = {st, cmd, grp, typ, rail, pay};
    return {b, crc_ref(b)};
  endfunction

  function automatic logic [31:0] ref_resp(input logic [1:0] st, input logic al,
                                           input logic [4:0] fl, input logic [15:0] rb);
    logic [28:0] b;
    b = {st, al, fl, rb, 5'b11111};
    return {b, crc_ref(b)};
  endfunction

  function automatic logic [1:0] ref_status(input logic [31:0] w);
    if (w[31:30] != 2'b01 || crc_ref(w[31:3]) != w[2:0]) return 2'b11;
    if (w[29:28] == 2'b01 || w[29:28] == 2'b10) return 2'b01;
    if (w[26:23] != 4'h0) return 2'b01;
    if (!w[27] && w[22:19] != RAIL) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, output logic [31:0] r);
    for (int i = 31; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b1;
      mosi = w[i];
      repeat (HP) @(negedge clk);
      r[i] = miso;
      sclk = 1'b0;
      repeat (HP - 1) @(negedge clk);
    end
    @(negedge clk);
    mosi = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] w, input string req);
    logic [31:0] r;
    logic [1:0]  st;
    int          v0;
    bit          apply;
    v0 = vld_cnt;
    send(w, r);
    chk(r == exp_resp, {req, " R7 reply"}, r, exp_resp);
    st = ref_status(w);
    apply = (st == 2'b00) && (w[29:28] == 2'b00);
    if (apply) exp_vt = w[18:3];
    exp_resp = ref_resp(st, alert, flags, exp_vt);
    chk(vt == exp_vt, {req, " target"}, 32'(vt), 32'(exp_vt));
    chk((vld_cnt - v0) == int'(apply), {req, " strobe count"}, 32'(vld_cnt - v0), 32'(apply));
    chk(miso == 1'b1, "R7 idle high", 32'(miso), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    exp_vt   = VTR;
    exp_resp = ref_resp(2'b00, 1'b0, 5'b0, VTR);
    chk(miso == 1'b1, "R1 line high", 32'(miso), 32'h1);
    chk(vt == VTR, "R1 target reset", 32'(vt), 32'(VTR));
    chk(vld == 1'b0, "R1 strobe low", 32'(vld), 32'h0);

    // R1 first reply, R3 addressed write
    flags = 5'h15; alert = 1'b1;
    frame(mk(2'b01, 2'b00, 1'b0, 4'h0, RAIL, 16'h1234), "R1 R3 write");
    flags = 5'h0A; alert = 1'b0;
    frame(mk(2'b01, 2'b11, 1'b0, 4'h0, RAIL, 16'hDEAD), "R6 read");
    frame(mk(2'b01, 2'b00, 1'b1, 4'h0, 4'h9, 16'hFFFF), "R5 group");
    frame(mk(2'b01, 2'b00, 1'b0, 4'h0, 4'h9, 16'h0101), "R5 other rail");
    frame(mk(2'b01, 2'b00, 1'b0, 4'h5, RAIL, 16'h0202), "R5 type");
    w = mk(2'b01, 2'b00, 1'b0, 4'h0, RAIL, 16'h0303);
    frame(w ^ 32'h0000_0010, "R4 corrupt");
    frame(mk(2'b00, 2'b00, 1'b0, 4'h0, RAIL, 16'h0404), "R9 bad start");
    frame(mk(2'b00, 2'b01, 1'b0, 4'h0, 4'h9, 16'h0505), "R9 over R8");
    frame(mk(2'b01, 2'b01, 1'b0, 4'h0, RAIL, 16'h0606), "R8 cmd01");
    frame(mk(2'b01, 2'b10, 1'b1, 4'h0, RAIL, 16'h0707), "R8 cmd10");
    frame(mk(2'b01, 2'b00, 1'b0, 4'h0, RAIL, 16'h0000), "R3 zero");
    frame(mk(2'b01, 2'b00, 1'b0, 4'h0, RAIL, 16'h0000), "R3 same value");
    // R2: serial clocks with data high must not open a frame
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); sclk = 1'b1;
      repeat (HP) @(negedge clk); sclk = 1'b0;
      repeat (HP) @(negedge clk);
    end
    frame(mk(2'b01, 2'b11, 1'b0, 4'h0, RAIL, 16'h0000), "R2 idle clocks");

    for (int n = 0; n < 70; n++) begin
      logic [1:0]  cmd;
      logic [3:0]  typ, rail;
      cmd   = 2'($urandom_range(0, 3));
      typ   = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
      rail  = ($urandom_range(0, 4) < 3) ? RAIL : 4'($urandom);
      w     = mk(2'b01, cmd, 1'($urandom), typ, rail, 16'($urandom));
      if ($urandom_range(0, 6) == 0) w = w ^ (32'h1 << $urandom_range(0, 31));
      flags = 5'($urandom);
      alert = 1'($urandom);
      frame(w, "R3 R4 R5 random");
    end
    frame(mk(2'b01, 2'b11, 1'b0, 4'h0, RAIL, 16'h0000), "R6 final read");

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule